// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the exchange point between a host processor and an embedded power-management controller. The host fills a 16-byte payload area and two pointer registers, then writes a command word. If the mailbox is idle, that write is taken as a new request. The mailbox marks itself busy, raises a one-cycle doorbell toward the controller, and shows the command, pointers and payload on the controller-side outputs.

The controller stores up to four response words into a response area that the host can only read. It then finishes the request through a valid/ready completion port, which carries an error flag and an 8-bit error code. The handshake is ready only while a request is outstanding. A completion offered while the mailbox is idle is never accepted, so the controller must hold `cpl_valid` until it sees `cpl_ready`.

On completion the mailbox sets a sticky done flag. If the command asked for it, the mailbox also drives a host interrupt. The host acknowledges by writing the status word back with the done bit set.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset every defined register reads zero, and `doorbell`, `host_irq` and `cpl_ready` are low.
- R2: A host write to offset 0x00 while idle stores the word as the command (read back at 0x00 and shown on `ctl_cmd_word`). It sets busy (status bit 0) and makes `doorbell` high for exactly the one cycle after the write edge. Command fields: code in bits 7:0, request-interrupt in bit 8, subcommand from bit 12, payload length in bytes from bit 16.
- R3: A host write to offset 0x00 while busy is ignored: the command register is unchanged and no doorbell is raised.
- R4: `cpl_ready` equals busy. A completion is accepted only when `cpl_valid` and `cpl_ready` are both high. An accepted completion clears busy and sets the done flag (status bit 2). A completion offered while idle changes nothing.
- R5: An accepted completion latches its error flag into status bit 1. When that flag is set, it latches `cpl_code` into status bits 23:16; otherwise bits 23:16 read zero. Codes: 0 none, 1 unsupported, 2 not serviced, 3 cannot service, 4 invalid, 5 failed, 6 security reject, 7 unsigned image.
- R6: `host_irq` is high exactly when the done flag is set and bit 8 of the most recently accepted command is set.
- R7: Writing offset 0x04 with bit 2 set clears the done flag; writing it with bit 2 clear leaves the flag alone. If a completion is accepted in the same cycle as the clear, the completion wins and the flag stays set.
- R8: Offsets 0x08 (source pointer) and 0x0C (destination pointer) are host read/write and drive `ctl_src_ptr` and `ctl_dst_ptr`.
- R9: Offsets 0x80, 0x84, 0x88 and 0x8C are four host read/write payload words. Word i appears on `ctl_payload[32*i+31:32*i]`.
- R10: Offsets 0x90 to 0x9C read response words 0 to 3. Only the controller writes them, through `rsp_we`, `rsp_idx` and `rsp_data`; host writes there have no effect.
- R11: Reads of any other offset, including any offset with bits 1:0 non-zero, return zero. Writes to those offsets change no register.
- R12: An accepted command clears the error bit and the error code of the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr_en | input | 1 | Host write strobe |
| h_addr | input | AW | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_addr` (combinational) |
| doorbell | output | 1 | One-cycle pulse on each accepted command |
| ctl_cmd_word | output | 32 | Current command word |
| ctl_src_ptr | output | 32 | Source pointer |
| ctl_dst_ptr | output | 32 | Destination pointer |
| ctl_payload | output | 128 | Payload words, word 0 in the low bits |
| rsp_we | input | 1 | Controller response word write |
| rsp_idx | input | 2 | Response word index |
| rsp_data | input | 32 | Response word data |
| cpl_valid | input | 1 | Controller offers a completion |
| cpl_ready | output | 1 | Completion can be taken (request outstanding) |
| cpl_err | input | 1 | Completion error flag |
| cpl_code | input | 8 | Completion error code |
| host_irq | output | 1 | Host interrupt |

## Verification
Directed cases separate the edge orderings that a random mix rarely hits:
- a command written while busy, which must not ring twice;
- a completion offered while idle, which must be dropped;
- a status clear that lands on the same edge as a completion, where the set must win;
- a clean completion that carries a non-zero code, which must read as zero.

Random sequences then interleave payload, pointer, response and command writes, completions with random error codes, and status clears. These are checked against a bench model, so stale error codes, lost interrupt enables and buffer aliasing show up as read mismatches. Random addresses over the whole offset space, including misaligned ones, separate the defined registers from the holes that must read zero.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW          = 32;
  localparam int BUF_WORDS   = 4;
  localparam int IDX_W       = $clog2(BUF_WORDS);
  localparam int RGN_LSB     = IDX_W + 2;
  localparam int CODE_W      = 8;
  localparam int CMD_IEN_BIT = 8;
  localparam int CLR_BIT     = 2;

  localparam logic [7:0] OFF_CMD  = 8'h00;
  localparam logic [7:0] OFF_STS  = 8'h04;
  localparam logic [7:0] OFF_SPTR = 8'h08;
  localparam logic [7:0] OFF_DPTR = 8'h0C;
  localparam logic [7:0] OFF_WBUF = 8'h80;
  localparam logic [7:0] OFF_RBUF = 8'h90;

  typedef enum logic [CODE_W-1:0] {
    EC_NONE          = 8'd0,
    EC_UNSUPPORTED   = 8'd1,
    EC_NOT_SERVICED  = 8'd2,
    EC_CANNOT_SERVE  = 8'd3,
    EC_INVALID       = 8'd4,
    EC_FAILED        = 8'd5,
    EC_SECURITY      = 8'd6,
    EC_UNSIGNED      = 8'd7
  } err_code_e;

  typedef struct packed {
    logic [7:0]        rsv_hi;
    logic [CODE_W-1:0] code;
    logic [12:0]       rsv_lo;
    logic              done;
    logic              err;
    logic              busy;
  } status_t;
endpackage

// File: rtl/mbox_hostregs.sv
module mbox_hostregs
  import mbox_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_sptr,
  input  logic                    we_dptr,
  input  logic                    we_wbuf,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           sptr,
  output logic [DW-1:0]           dptr,
  output logic [BUF_WORDS*DW-1:0] wbuf_flat,
  output logic [DW-1:0]           wbuf_rd
);
  logic [DW-1:0] words [BUF_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sptr <= '0;
      dptr <= '0;
    end else begin
      if (we_sptr) sptr <= wdata;
      if (we_dptr) dptr <= wdata;
    end
  end

  for (genvar i = 0; i < BUF_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[i] <= '0;
      else if (we_wbuf && idx == IDX_W'(i))
        words[i] <= wdata;
    end
    assign wbuf_flat[i*DW +: DW] = words[i];
  end

  assign wbuf_rd = words[idx];
endmodule

// File: rtl/mbox_rspbuf.sv
module mbox_rspbuf
  import mbox_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    c_we,
  input  logic [IDX_W-1:0]        c_idx,
  input  logic [DW-1:0]           c_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [BUF_WORDS*DW-1:0] rbuf_flat,
  output logic [DW-1:0]           rd_data
);
  logic [DW-1:0] words [BUF_WORDS];

  for (genvar i = 0; i < BUF_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[i] <= '0;
      else if (c_we && c_idx == IDX_W'(i))
        words[i] <= c_data;
    end
    assign rbuf_flat[i*DW +: DW] = words[i];
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              sts_we,
  input  logic [DW-1:0]     wdata,
  input  logic              cpl_valid,
  input  logic              cpl_err,
  input  logic [CODE_W-1:0] cpl_code,
  output logic              cpl_ready,
  output logic              doorbell,
  output logic [DW-1:0]     cmd_word,
  output logic [DW-1:0]     sts_word,
  output logic              irq,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CODE_W-1:0] code
);
  logic    accept;
  logic    cpl_fire;
  status_t sts;

  assign accept   = cmd_we && !busy;
  assign cpl_fire = cpl_valid && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word <= '0;
      busy     <= 1'b0;
      doorbell <= 1'b0;
      err      <= 1'b0;
      code     <= '0;
    end else begin
      doorbell <= 1'b0;
      if (accept) begin
        cmd_word <= wdata;
        busy     <= 1'b1;
        doorbell <= 1'b1;
        err      <= 1'b0;
        code     <= '0;
      end else if (cpl_fire) begin
        busy <= 1'b0;
        err  <= cpl_err;
        code <= cpl_err ? cpl_code : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      done <= 1'b0;
    else if (cpl_fire)
      done <= 1'b1;
    else if (sts_we && wdata[CLR_BIT])
      done <= 1'b0;
  end

  always_comb begin
    sts      = '0;
    sts.busy = busy;
    sts.err  = err;
    sts.done = done;
    sts.code = code;
  end

  assign sts_word  = sts;
  assign cpl_ready = busy;
  assign irq       = done && cmd_word[CMD_IEN_BIT];
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbox_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    h_wr_en,
  input  logic [AW-1:0]           h_addr,
  input  logic [DW-1:0]           h_wdata,
  output logic [DW-1:0]           h_rdata,
  output logic                    doorbell,
  output logic [DW-1:0]           ctl_cmd_word,
  output logic [DW-1:0]           ctl_src_ptr,
  output logic [DW-1:0]           ctl_dst_ptr,
  output logic [BUF_WORDS*DW-1:0] ctl_payload,
  input  logic                    rsp_we,
  input  logic [IDX_W-1:0]        rsp_idx,
  input  logic [DW-1:0]           rsp_data,
  input  logic                    cpl_valid,
  output logic                    cpl_ready,
  input  logic                    cpl_err,
  input  logic [CODE_W-1:0]       cpl_code,
  output logic                    host_irq
);
  localparam logic [AW-1:0] A_CMD  = AW'(OFF_CMD);
  localparam logic [AW-1:0] A_STS  = AW'(OFF_STS);
  localparam logic [AW-1:0] A_SPTR = AW'(OFF_SPTR);
  localparam logic [AW-1:0] A_DPTR = AW'(OFF_DPTR);
  localparam logic [AW-1:0] A_WBUF = AW'(OFF_WBUF);
  localparam logic [AW-1:0] A_RBUF = AW'(OFF_RBUF);

  logic                    aligned;
  logic                    sel_cmd, sel_sts, sel_sptr, sel_dptr, in_wbuf, in_rbuf;
  logic [IDX_W-1:0]        buf_idx;
  logic [DW-1:0]           sts_word, wbuf_rd, rbuf_rd;
  logic [BUF_WORDS*DW-1:0] rbuf_flat;
  logic                    sts_busy, sts_done, sts_err;
  logic [CODE_W-1:0]       sts_code;

  assign aligned  = (h_addr[1:0] == 2'b00);
  assign sel_cmd  = (h_addr == A_CMD);
  assign sel_sts  = (h_addr == A_STS);
  assign sel_sptr = (h_addr == A_SPTR);
  assign sel_dptr = (h_addr == A_DPTR);
  assign in_wbuf  = aligned && (h_addr[AW-1:RGN_LSB] == A_WBUF[AW-1:RGN_LSB]);
  assign in_rbuf  = aligned && (h_addr[AW-1:RGN_LSB] == A_RBUF[AW-1:RGN_LSB]);
  assign buf_idx  = h_addr[RGN_LSB-1:2];

  mbox_hostregs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_sptr   (h_wr_en && sel_sptr),
    .we_dptr   (h_wr_en && sel_dptr),
    .we_wbuf   (h_wr_en && in_wbuf),
    .idx       (buf_idx),
    .wdata     (h_wdata),
    .sptr      (ctl_src_ptr),
    .dptr      (ctl_dst_ptr),
    .wbuf_flat (ctl_payload),
    .wbuf_rd   (wbuf_rd)
  );

  mbox_rspbuf u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .c_we      (rsp_we),
    .c_idx     (rsp_idx),
    .c_data    (rsp_data),
    .rd_idx    (buf_idx),
    .rbuf_flat (rbuf_flat),
    .rd_data   (rbuf_rd)
  );

  mbox_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (h_wr_en && sel_cmd),
    .sts_we    (h_wr_en && sel_sts),
    .wdata     (h_wdata),
    .cpl_valid (cpl_valid),
    .cpl_err   (cpl_err),
    .cpl_code  (cpl_code),
    .cpl_ready (cpl_ready),
    .doorbell  (doorbell),
    .cmd_word  (ctl_cmd_word),
    .sts_word  (sts_word),
    .irq       (host_irq),
    .busy      (sts_busy),
    .done      (sts_done),
    .err       (sts_err),
    .code      (sts_code)
  );

  always_comb begin
    h_rdata = '0;
    if (sel_cmd)       h_rdata = ctl_cmd_word;
    else if (sel_sts)  h_rdata = sts_word;
    else if (sel_sptr) h_rdata = ctl_src_ptr;
    else if (sel_dptr) h_rdata = ctl_dst_ptr;
    else if (in_wbuf)  h_rdata = wbuf_rd;
    else if (in_rbuf)  h_rdata = rbuf_rd;
  end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
  import mbox_pkg::*;
#(
  parameter int AW = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    doorbell,
  input logic                    busy,
  input logic                    done,
  input logic                    err,
  input logic [CODE_W-1:0]       code,
  input logic                    host_irq,
  input logic                    cpl_valid,
  input logic                    cpl_ready,
  input logic                    h_wr_en,
  input logic [AW-1:0]           h_addr,
  input logic [DW-1:0]           h_wdata,
  input logic                    rsp_we,
  input logic [BUF_WORDS*DW-1:0] rbuf_flat
);
  localparam logic [AW-1:0] A_CMD = AW'(OFF_CMD);
  localparam logic [AW-1:0] A_STS = AW'(OFF_STS);

  AST_DB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell); // R2
  AST_DB_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> busy); // R2
  AST_NO_DB_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && h_wr_en && h_addr == A_CMD) |=> !doorbell); // R3
  AST_CPL_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_ready) |=> (!busy && done)); // R4
  AST_IDLE_CPL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(h_wr_en && h_addr == A_CMD)) |=> !busy); // R4
  AST_CODE_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> (code == '0)); // R5
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> done); // R6
  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr_en && h_addr == A_STS && h_wdata[CLR_BIT] && !(cpl_valid && cpl_ready))
      |=> !done); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_we |=> $stable(rbuf_flat)); // R10
  AST_NEW_REQ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> !err); // R12
endmodule

bind cmd_mailbox mbox_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .doorbell  (doorbell),
  .busy      (sts_busy),
  .done      (sts_done),
  .err       (sts_err),
  .code      (sts_code),
  .host_irq  (host_irq),
  .cpl_valid (cpl_valid),
  .cpl_ready (cpl_ready),
  .h_wr_en   (h_wr_en),
  .h_addr    (h_addr),
  .h_wdata   (h_wdata),
  .rsp_we    (rsp_we),
  .rbuf_flat (rbuf_flat)
);

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         h_wr_en = 1'b0;
  logic [7:0]   h_addr = '0;
  logic [31:0]  h_wdata = '0;
  logic [31:0]  h_rdata;
  logic         doorbell;
  logic [31:0]  ctl_cmd_word, ctl_src_ptr, ctl_dst_ptr;
  logic [127:0] ctl_payload;
  logic         rsp_we = 1'b0;
  logic [1:0]   rsp_idx = '0;
  logic [31:0]  rsp_data = '0;
  logic         cpl_valid = 1'b0;
  logic         cpl_ready;
  logic         cpl_err = 1'b0;
  logic [7:0]   cpl_code = '0;
  logic         host_irq;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_cmd, m_sptr, m_dptr;
  logic [31:0] m_wb [4];
  logic [31:0] m_rb [4];
  logic        m_busy, m_err, m_done, m_db;
  logic [7:0]  m_code;

  always #4 clk = ~clk;

  cmd_mailbox u0 (.*);

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [31:0] exp_sts();
    return {8'h00, m_code, 13'h0, m_done, m_err, m_busy};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a == 8'h00) return m_cmd;
    if (a == 8'h04) return exp_sts();
    if (a == 8'h08) return m_sptr;
    if (a == 8'h0C) return m_dptr;
    if (a[7:4] == 4'h8) return m_wb[a[3:2]];
    if (a[7:4] == 4'h9) return m_rb[a[3:2]];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    h_wr_en = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_wr_en = 1'b0;
    m_db = 1'b0;
    if (a[1:0] == 2'b00) begin
      if (a == 8'h00 && !m_busy) begin
        m_cmd = d; m_busy = 1'b1; m_err = 1'b0; m_code = '0; m_db = 1'b1;
      end else if (a == 8'h04 && d[2]) m_done = 1'b0;
      else if (a == 8'h08) m_sptr = d;
      else if (a == 8'h0C) m_dptr = d;
      else if (a[7:4] == 4'h8) m_wb[a[3:2]] = d;
    end
    if (a == 8'h00) chk("R2/R3 doorbell", 128'(doorbell), 128'(m_db));
  endtask

  task automatic ctl_rsp(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk);
    rsp_we = 1'b1; rsp_idx = i; rsp_data = d;
    @(negedge clk);
    rsp_we = 1'b0;
    m_rb[i] = d;
  endtask

  task automatic ctl_cpl(input logic e, input logic [7:0] c);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_err = e; cpl_code = c;
    @(negedge clk);
    cpl_valid = 1'b0;
    if (m_busy) begin
      m_busy = 1'b0; m_err = e; m_code = e ? c : 8'h0; m_done = 1'b1;
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    @(negedge clk);
    h_addr = a;
    #1;
    chk(req, 128'(h_rdata), 128'(exp_rd(a)));
  endtask

  task automatic outs_chk(input string req);
    #1;
    chk({req, " R2 cmd out"}, 128'(ctl_cmd_word), 128'(m_cmd));
    chk({req, " R8 ptrs"}, {64'h0, ctl_src_ptr, ctl_dst_ptr}, {64'h0, m_sptr, m_dptr});
    chk({req, " R9 payload"}, ctl_payload, {m_wb[3], m_wb[2], m_wb[1], m_wb[0]});
    chk({req, " R4 ready"}, 128'(cpl_ready), 128'(m_busy));
    chk({req, " R6 irq"}, 128'(host_irq), 128'(m_done && m_cmd[8]));
  endtask

  initial begin
    m_cmd = '0; m_sptr = '0; m_dptr = '0;
    m_busy = 0; m_err = 0; m_done = 0; m_db = 0; m_code = '0;
    for (int i = 0; i < 4; i++) begin m_wb[i] = '0; m_rb[i] = '0; end
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(8'h00, "R1 cmd");
    rd_chk(8'h04, "R1 status");
    rd_chk(8'h88, "R1 wbuf");
    chk("R1 doorbell", 128'(doorbell), 128'(0));
    outs_chk("R1");

    // R8 pointers, R9 payload
    host_wr(8'h08, 32'h1000_2000);
    host_wr(8'h0C, 32'hCAFE_0040);
    rd_chk(8'h08, "R8 sptr");
    rd_chk(8'h0C, "R8 dptr");
    for (int i = 0; i < 4; i++) host_wr(8'h80 + 8'(4*i), 32'hA0A0_0000 + 32'(i));
    for (int i = 0; i < 4; i++) rd_chk(8'h80 + 8'(4*i), "R9 wbuf");
    outs_chk("R8R9");

    // R10 host cannot write response words; controller can
    host_wr(8'h94, 32'hDEAD_BEEF);
    rd_chk(8'h94, "R10 host write ignored");
    ctl_rsp(2'd1, 32'h1234_5678);
    ctl_rsp(2'd3, 32'h8765_4321);
    rd_chk(8'h94, "R10 rsp word1");
    rd_chk(8'h9C, "R10 rsp word3");

    // R11 holes and misaligned
    host_wr(8'h10, 32'hFFFF_FFFF);
    host_wr(8'h81, 32'h5555_5555);
    rd_chk(8'h10, "R11 hole");
    rd_chk(8'h81, "R11 misaligned");
    rd_chk(8'h40, "R11 hole2");
    rd_chk(8'h80, "R11 wbuf untouched");

    // R2 command with interrupt request
    host_wr(8'h00, 32'h0010_3105);
    @(negedge clk);
    chk("R2 doorbell one cycle", 128'(doorbell), 128'(0));
    rd_chk(8'h04, "R2 busy");
    outs_chk("R2");
    // R3 write while busy
    host_wr(8'h00, 32'h0000_00FF);
    rd_chk(8'h00, "R3 cmd unchanged");
    // R4 R5 R6 completion with error code 6
    ctl_cpl(1'b1, 8'd6);
    rd_chk(8'h04, "R5 err code");
    outs_chk("R4R6");
    // R7 clear with bit2 low does nothing, then clear
    host_wr(8'h04, 32'h0000_0003);
    rd_chk(8'h04, "R7 no clear");
    host_wr(8'h04, 32'h0000_0004);
    rd_chk(8'h04, "R7 cleared");
    chk("R7 irq low", 128'(host_irq), 128'(0));

    // R12 new command clears err; R5 clean completion masks code; R6 no ien
    host_wr(8'h00, 32'h0000_2007);
    rd_chk(8'h04, "R12 err cleared");
    ctl_cpl(1'b0, 8'd5);
    rd_chk(8'h04, "R5 code zero on success");
    chk("R6 no irq without request", 128'(host_irq), 128'(0));
    // R4 completion while idle ignored
    ctl_cpl(1'b1, 8'd3);
    rd_chk(8'h04, "R4 idle completion dropped");

    // R7 same-cycle clear and completion: completion wins
    host_wr(8'h00, 32'h0004_0102);
    @(negedge clk);
    h_wr_en = 1'b1; h_addr = 8'h04; h_wdata = 32'h4;
    cpl_valid = 1'b1; cpl_err = 1'b1; cpl_code = 8'd7;
    @(negedge clk);
    h_wr_en = 1'b0; cpl_valid = 1'b0;
    m_busy = 0; m_err = 1; m_code = 8'd7; m_done = 1;
    rd_chk(8'h04, "R7 completion wins");
    outs_chk("R7");

    // random mix
    for (int n = 0; n < 500; n++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: host_wr(8'h80 + 8'(4*$urandom_range(0, 3)), $urandom);
        1: host_wr($urandom_range(0, 1) ? 8'h08 : 8'h0C, $urandom);
        2: ctl_rsp(2'($urandom_range(0, 3)), $urandom);
        3: rd_chk(8'($urandom_range(0, 255)), "R11 random read");
        4: host_wr(8'h00, $urandom);
        5: ctl_cpl(1'($urandom_range(0, 1)), 8'($urandom_range(0, 7)));
        default: host_wr(8'h04, $urandom);
      endcase
      rd_chk(8'h04, "R5 random status");
      if (n % 25 == 0) begin
        for (int i = 0; i < 4; i++) rd_chk(8'h90 + 8'(4*i), "R10 random rsp");
        outs_chk("R9 random");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule